// File: doc/BRIEF.md
# Operand-Gathering Computation Unit Controller

This block sits in front of a small arithmetic unit in a scoreboard-driven pipeline. A single-cycle issue pulse latches an operation and raises a busy flag. The unit then asks for its two source operands, each through its own request/grant pair: the unit raises a request and the producer answers with a one-cycle grant that carries the data. Once every operand it needs is in hand, the unit passes the operands to an internal 16-bit add/subtract unit over a valid/ready handshake. It then offers the result through a third request/grant pair. Busy drops once the result has been taken.

Either read can be left out. A per-port mask input leaves a read out. So does the operation itself: it can force operand A to zero or replace operand B with an immediate. A read that is left out never raises its request. Operand A can also be inverted bitwise before it reaches the arithmetic unit. When both reads are left out, the unit goes straight from issue to the arithmetic stage.

Top module: `cu_opgather`

## Requirements
- R1: While busy_o is low, a pulse on issue_i captures the operation fields and sets busy_o. busy_o then stays high until the result grant. An issue_i pulse while busy_o is high changes nothing: not the result, not the requests and not the timing.
- R2: A read request that is needed is low during the issue cycle and high in the cycle right after it. Port 0 carries operand A and port 1 carries operand B.
- R3: A raised read request stays high until its grant rd_go_i is seen. It is low in the cycle after the grant and does not rise again in the same busy period. The grant may come in the first cycle the request is high. Data on the source input is taken only in the grant cycle.
- R4: Bit p of rdmask_i, sampled at issue, keeps read request p low for the whole busy period. A masked operand enters the arithmetic stage as zero.
- R5: With zero_a_i set, operand A is not requested and is taken as zero. With imm_ok_i set, operand B is not requested and imm_i is used in its place.
- R6: With invert_i set, operand A is inverted bitwise after any zero substitution. For example, 5 inverted plus 2 gives 0xFFFC, and zero inverted gives 0xFFFF.
- R7: Operation code 0 adds A and B. The write request first rises ADD_LAT+1 cycles after the cycle of the last operand grant. Every other code subtracts B from A, and the write request first rises in the cycle after the last grant. When no read is needed, the issue cycle counts as the last grant cycle.
- R8: Once raised, wr_rel_o and result_o hold steady until a one-cycle wr_go_i. result_o is valid in that cycle. busy_o and wr_rel_o are low in the cycle that follows.
- R9: A synchronous reset, even in the middle of an operation, leaves busy_o and every request low from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_i | input | 1 | One-cycle operation issue pulse |
| op_code_i | input | 2 | Operation: 0 add, others subtract |
| invert_i | input | 1 | Invert operand A |
| zero_a_i | input | 1 | Take operand A as zero, skip its read |
| imm_ok_i | input | 1 | Use the immediate for operand B, skip its read |
| imm_i | input | W | Immediate value |
| rdmask_i | input | 2 | Per-port read suppression, held while busy |
| busy_o | output | 1 | Operation in flight |
| rd_rel_o | output | 2 | Read requests, bit 0 operand A, bit 1 operand B |
| rd_go_i | input | 2 | Read grants, one cycle each |
| src_a_i | input | W | Operand A data, valid with rd_go_i[0] |
| src_b_i | input | W | Operand B data, valid with rd_go_i[1] |
| wr_rel_o | output | 1 | Result ready for writing |
| wr_go_i | input | 1 | Result grant, one cycle |
| result_o | output | W | Result, valid while wr_rel_o is high |

## Verification
The read requests are due one cycle after the issue edge. Each one falls one cycle after its grant. The write request is due one cycle after the last grant for subtraction and ADD_LAT+1 cycles after it for addition. busy_o falls one cycle after the write grant. The bench counts cycles from the issue edge. At every falling edge it compares each request and busy_o with a value worked out from that count and from the grant cycles the bench itself chose. Grants are driven in the same half-cycle, so every sample lands on a settled register state.

// File: rtl/cu_pkg.sv
package cu_pkg;
   typedef enum logic [1:0] {
      CU_OP_ADD = 2'd0,
      CU_OP_SUB = 2'd1,
      CU_OP_NOP = 2'd2,
      CU_OP_ALT = 2'd3
   } cu_op_e;

   localparam int CU_NRD = 2;
endpackage

// File: rtl/cu_read_port.sv
module cu_read_port #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         start_i,
   input  logic         need_i,
   input  logic [W-1:0] preset_i,
   input  logic         go_i,
   input  logic [W-1:0] src_i,
   output logic         rel_o,
   output logic [W-1:0] opnd_o
);
   logic         pend_q;
   logic [W-1:0] val_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q <= 1'b0;
         val_q  <= '0;
      end else if (start_i) begin
         pend_q <= need_i;
         val_q  <= preset_i;
      end else if (pend_q && go_i) begin
         pend_q <= 1'b0;
         val_q  <= src_i;
      end
   end

   assign rel_o  = pend_q;
   // data is forwarded in the grant cycle itself
   assign opnd_o = (pend_q && go_i) ? src_i : val_q;

   // R3
   rel_hold_chk: assert property (@(posedge clk) disable iff (rst)
      rel_o && !go_i |=> rel_o);
   // R3
   rel_drop_chk: assert property (@(posedge clk) disable iff (rst)
      rel_o && go_i |=> !rel_o);
   // R3
   rel_no_rerise_chk: assert property (@(posedge clk) disable iff (rst)
      !rel_o && !start_i |=> !rel_o);
endmodule

// File: rtl/cu_alu.sv
module cu_alu
   import cu_pkg::*;
#(
   parameter int W       = 16,
   parameter int ADD_LAT = 3
) (
   input  logic         clk,
   input  logic         rst,
   input  cu_op_e       op_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         in_valid_i,
   output logic         in_ready_o,
   output logic         out_valid_o,
   input  logic         out_ready_i,
   output logic [W-1:0] out_data_o
);
   localparam int CW = $clog2(ADD_LAT + 1);

   logic         run_q;
   logic [W-1:0] acc_q;
   logic         is_add;
   logic         accept;
   logic         cnt_zero;

   assign is_add = (op_i == CU_OP_ADD);
   assign accept = !run_q && is_add && in_valid_i;

   generate
      if (ADD_LAT == 1) begin : g_lat1
         assign cnt_zero = 1'b1;
      end else begin : g_latn
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (rst)
               cnt_q <= '0;
            else if (accept)
               cnt_q <= CW'(ADD_LAT - 1);
            else if (run_q && cnt_q != '0)
               cnt_q <= cnt_q - 1'b1;
         end
         assign cnt_zero = (cnt_q == '0);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q <= 1'b0;
         acc_q <= '0;
      end else if (accept) begin
         run_q <= 1'b1;
         acc_q <= a_i + b_i;
      end else if (run_q && cnt_zero && out_ready_i) begin
         run_q <= 1'b0;
      end
   end

   always_comb begin
      if (!run_q && !is_add) begin
         // zero-delay subtract path
         out_valid_o = in_valid_i;
         in_ready_o  = out_ready_i;
         out_data_o  = a_i - b_i;
      end else begin
         out_valid_o = run_q && cnt_zero;
         in_ready_o  = !run_q;
         out_data_o  = acc_q;
      end
   end

   // R7
   alu_out_hold_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid_o && !out_ready_i |=> out_valid_o);
endmodule

// File: rtl/cu_opgather.sv
module cu_opgather
   import cu_pkg::*;
#(
   parameter int W       = 16,
   parameter int ADD_LAT = 3
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         issue_i,
   input  logic [1:0]   op_code_i,
   input  logic         invert_i,
   input  logic         zero_a_i,
   input  logic         imm_ok_i,
   input  logic [W-1:0] imm_i,
   input  logic [1:0]   rdmask_i,
   output logic         busy_o,
   output logic [1:0]   rd_rel_o,
   input  logic [1:0]   rd_go_i,
   input  logic [W-1:0] src_a_i,
   input  logic [W-1:0] src_b_i,
   output logic         wr_rel_o,
   input  logic         wr_go_i,
   output logic [W-1:0] result_o
);
   generate
      if (W < 2) begin : g_bad_w
         $error("cu_opgather: W must be at least 2");
      end
      if (ADD_LAT < 1) begin : g_bad_lat
         $error("cu_opgather: ADD_LAT must be at least 1");
      end
   endgenerate

   logic              busy_q;
   logic              sent_q;
   logic              inv_q;
   cu_op_e            op_q;
   logic              issue_ok;
   logic              finish;
   logic [CU_NRD-1:0] need;
   logic [W-1:0]      preset [CU_NRD];
   logic [W-1:0]      src    [CU_NRD];
   logic [W-1:0]      opnd   [CU_NRD];
   logic [W-1:0]      alu_a;
   logic              alu_in_valid, alu_in_ready, alu_out_valid;
   logic [W-1:0]      alu_out;

   assign issue_ok  = issue_i && !busy_q;
   assign need[0]   = !zero_a_i && !rdmask_i[0];
   assign need[1]   = !imm_ok_i && !rdmask_i[1];
   assign preset[0] = '0;
   assign preset[1] = imm_ok_i ? imm_i : '0;
   assign src[0]    = src_a_i;
   assign src[1]    = src_b_i;

   generate
      for (genvar g = 0; g < CU_NRD; g++) begin : g_rd
         cu_read_port #(.W(W)) u_rd (
            .clk      (clk),
            .rst      (rst),
            .start_i  (issue_ok),
            .need_i   (need[g]),
            .preset_i (preset[g]),
            .go_i     (rd_go_i[g]),
            .src_i    (src[g]),
            .rel_o    (rd_rel_o[g]),
            .opnd_o   (opnd[g])
         );
      end
   endgenerate

   assign alu_a        = inv_q ? ~opnd[0] : opnd[0];
   assign alu_in_valid = busy_q && (rd_rel_o == '0) && !sent_q;

   cu_alu #(.W(W), .ADD_LAT(ADD_LAT)) u_alu (
      .clk         (clk),
      .rst         (rst),
      .op_i        (op_q),
      .a_i         (alu_a),
      .b_i         (opnd[1]),
      .in_valid_i  (alu_in_valid),
      .in_ready_o  (alu_in_ready),
      .out_valid_o (alu_out_valid),
      .out_ready_i (wr_go_i),
      .out_data_o  (alu_out)
   );

   assign wr_rel_o = busy_q && alu_out_valid;
   assign result_o = alu_out;
   assign finish   = wr_rel_o && wr_go_i;
   assign busy_o   = busy_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q <= 1'b0;
         sent_q <= 1'b0;
         inv_q  <= 1'b0;
         op_q   <= CU_OP_ADD;
      end else if (issue_ok) begin
         busy_q <= 1'b1;
         sent_q <= 1'b0;
         inv_q  <= invert_i;
         op_q   <= cu_op_e'(op_code_i);
      end else begin
         if (alu_in_valid && alu_in_ready) sent_q <= 1'b1;
         if (finish) busy_q <= 1'b0;
      end
   end

   // R1
   busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
      busy_o && !finish |=> busy_o);
   // R1
   issue_ignored_chk: assert property (@(posedge clk) disable iff (rst)
      busy_o && issue_i |=> $stable(op_q) && $stable(inv_q));
   // R2
   rel_quiet_issue_chk: assert property (@(posedge clk) disable iff (rst)
      issue_ok |-> rd_rel_o == '0);
   // R8
   wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      wr_rel_o && !wr_go_i |=> wr_rel_o && $stable(result_o));
   // R8
   busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
      finish |=> !busy_o && !wr_rel_o);
   // R9
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> !busy_o && rd_rel_o == '0 && !wr_rel_o);
endmodule

// File: tb/cu_opgather_tb_top.sv
module cu_opgather_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int W          = 16;
   localparam int LAT        = 3;

   logic         clk = 1'b0;
   logic         rst;
   logic         issue_i;
   logic [1:0]   op_code_i;
   logic         invert_i, zero_a_i, imm_ok_i;
   logic [W-1:0] imm_i;
   logic [1:0]   rdmask_i;
   logic         busy_o;
   logic [1:0]   rd_rel_o;
   logic [1:0]   rd_go_i;
   logic [W-1:0] src_a_i, src_b_i;
   logic         wr_rel_o, wr_go_i;
   logic [W-1:0] result_o;

   int n_chk = 0;
   int n_err = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cu_opgather #(.W(W), .ADD_LAT(LAT)) dut_i (
      .clk(clk), .rst(rst), .issue_i(issue_i), .op_code_i(op_code_i),
      .invert_i(invert_i), .zero_a_i(zero_a_i), .imm_ok_i(imm_ok_i),
      .imm_i(imm_i), .rdmask_i(rdmask_i), .busy_o(busy_o),
      .rd_rel_o(rd_rel_o), .rd_go_i(rd_go_i), .src_a_i(src_a_i),
      .src_b_i(src_b_i), .wr_rel_o(wr_rel_o), .wr_go_i(wr_go_i),
      .result_o(result_o)
   );

   task automatic chk(input bit ok, input string req,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [W-1:0] model(input logic [W-1:0] a, b, imm,
         input logic [1:0] op, input bit inv, za, iok, input logic [1:0] mask);
      logic [W-1:0] ea, eb;
      ea = (za || mask[0]) ? '0 : a;
      if (inv) ea = ~ea;
      eb = iok ? imm : (mask[1] ? '0 : b);
      return (op == 2'd0) ? ea + eb : ea - eb;
   endfunction

   task automatic run_op(input logic [W-1:0] a, b, imm, input logic [1:0] op,
         input bit inv, za, iok, input logic [1:0] mask,
         input int da, db, dw, input bit spur);
      logic [1:0]   need;
      bit   [1:0]   done;
      int           cnt [2];
      int           dly [2];
      logic [W-1:0] vals [2];
      int           last_rd, t, cw, exp_wr;
      bit           wdone, all_done;
      logic [W-1:0] exp;
      string        rtag;
      need    = {!iok && !mask[1], !za && !mask[0]};
      exp     = model(a, b, imm, op, inv, za, iok, mask);
      vals[0] = a; vals[1] = b; dly[0] = da; dly[1] = db;
      cnt[0]  = 0; cnt[1] = 0;
      rtag    = inv ? "R6" : ((za || iok) ? "R5" : ((mask != 0) ? "R4" : "R7"));
      @(negedge clk);
      chk(rd_rel_o == 2'b00, "R2 quiet before issue", rd_rel_o, 0);
      chk(busy_o == 1'b0, "R1 idle before issue", busy_o, 0);
      issue_i = 1'b1; op_code_i = op; invert_i = inv; zero_a_i = za;
      imm_ok_i = iok; imm_i = imm; rdmask_i = mask;
      @(posedge clk);
      @(negedge clk);
      issue_i = 1'b0; op_code_i = 2'($urandom); invert_i = 1'($urandom);
      zero_a_i = 1'($urandom); imm_ok_i = 1'($urandom); imm_i = W'($urandom);
      done = ~need; last_rd = 0; t = 1; cw = 0; wdone = 1'b0;
      while (!wdone && t < 300) begin
         chk(busy_o == 1'b1, "R1 busy held", busy_o, 1);
         for (int p = 0; p < 2; p++) begin
            bit er;
            er = need[p] && !done[p];
            chk(rd_rel_o[p] == er,
                need[p] ? ((t == 1) ? "R2 request rise" : "R3 request") :
                          (mask[p] ? "R4 masked request" : "R5 skipped request"),
                rd_rel_o[p], er);
         end
         all_done = &done;
         exp_wr   = last_rd + 1 + ((op == 2'd0) ? LAT : 0);
         chk(wr_rel_o == (all_done && t >= exp_wr), "R7 write request timing",
             wr_rel_o, all_done && t >= exp_wr);
         for (int p = 0; p < 2; p++) begin
            if (need[p] && !done[p]) begin
               if (cnt[p] == dly[p]) begin
                  rd_go_i[p] = 1'b1;
                  if (p == 0) src_a_i = vals[0]; else src_b_i = vals[1];
                  done[p] = 1'b1;
                  last_rd = t;
               end else cnt[p]++;
            end
         end
         if (spur && t == 1) begin
            issue_i = 1'b1; op_code_i = ~op; invert_i = ~inv; rdmask_i = 2'b00;
            zero_a_i = 1'b0; imm_ok_i = 1'b0;
         end
         if (wr_rel_o) begin
            if (cw == dw) begin
               wr_go_i = 1'b1;
               wdone   = 1'b1;
               chk(result_o == exp, {rtag, " result"}, result_o, exp);
            end else cw++;
         end
         @(posedge clk);
         @(negedge clk);
         rd_go_i = 2'b00; wr_go_i = 1'b0; issue_i = 1'b0;
         src_a_i = W'($urandom); src_b_i = W'($urandom);
         t++;
      end
      if (!wdone) chk(1'b0, "R1 operation never finished", 0, 1);
      chk(busy_o == 1'b0, "R8 busy falls after write grant", busy_o, 0);
      chk(wr_rel_o == 1'b0, "R8 write request drops", wr_rel_o, 0);
      rdmask_i = 2'b00;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED));
      rst = 1'b1; issue_i = 1'b0; op_code_i = 2'd0; invert_i = 1'b0;
      zero_a_i = 1'b0; imm_ok_i = 1'b0; imm_i = '0; rdmask_i = 2'b00;
      rd_go_i = 2'b00; src_a_i = '0; src_b_i = '0; wr_go_i = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(busy_o == 1'b0, "R9 reset busy", busy_o, 0);
      chk(rd_rel_o == 2'b00, "R9 reset read requests", rd_rel_o, 0);
      chk(wr_rel_o == 1'b0, "R9 reset write request", wr_rel_o, 0);
      rst = 1'b0;

      // directed corner cases
      run_op(16'd5, 16'd2, 16'd8, 2'd0, 0, 0, 0, 2'b00, 0, 0, 0, 0); // R7 add 7
      run_op(16'd5, 16'd2, 16'd8, 2'd0, 1, 0, 0, 2'b00, 1, 0, 2, 0); // R6 0xFFFC
      run_op(16'd5, 16'd2, 16'd8, 2'd0, 0, 1, 1, 2'b00, 0, 0, 1, 0); // R5 both skipped -> 8
      run_op(16'd5, 16'd2, 16'd8, 2'd0, 0, 1, 0, 2'b00, 0, 2, 0, 0); // R5 zero A -> 2
      run_op(16'd5, 16'd2, 16'd8, 2'd2, 0, 0, 0, 2'b00, 2, 0, 0, 0); // R7 subtract 3
      run_op(16'd5, 16'd2, 16'd8, 2'd1, 0, 1, 1, 2'b00, 0, 0, 0, 0); // R7 no reads, subtract
      run_op(16'd9, 16'd4, 16'd0, 2'd0, 1, 1, 0, 2'b00, 0, 0, 0, 0); // R6 zero then invert
      run_op(16'd9, 16'd4, 16'd0, 2'd3, 0, 0, 0, 2'b01, 0, 1, 0, 0); // R4 mask A
      run_op(16'd9, 16'd4, 16'd0, 2'd0, 0, 0, 0, 2'b11, 0, 0, 3, 0); // R4 mask both
      run_op(16'd30, 16'd7, 16'd0, 2'd0, 0, 0, 0, 2'b00, 2, 1, 1, 1); // R1 issue while busy
      run_op(16'd30, 16'd7, 16'd0, 2'd1, 0, 0, 0, 2'b10, 0, 0, 0, 1); // R1 issue while busy

      // R9 reset in the middle of an operation
      @(negedge clk);
      issue_i = 1'b1; op_code_i = 2'd0; zero_a_i = 1'b0; imm_ok_i = 1'b0;
      rdmask_i = 2'b00; invert_i = 1'b0;
      @(posedge clk);
      @(negedge clk);
      issue_i = 1'b0;
      chk(rd_rel_o == 2'b11, "R2 both requests up", rd_rel_o, 2'b11);
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      chk(busy_o == 1'b0, "R9 mid-op reset busy", busy_o, 0);
      chk(rd_rel_o == 2'b00, "R9 mid-op reset requests", rd_rel_o, 0);
      chk(wr_rel_o == 1'b0, "R9 mid-op reset write", wr_rel_o, 0);

      // constrained random
      for (int i = 0; i < 60; i++) begin
         run_op(W'($urandom), W'($urandom), W'($urandom), 2'($urandom),
                1'($urandom), ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0),
                ($urandom_range(0, 4) == 0) ? 2'($urandom) : 2'b00,
                $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
                ($urandom_range(0, 5) == 0));
      end

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule